// File: doc/BRIEF.md
# Branch and Skip Next-PC Unit

This unit decides where program flow goes after one instruction of a 16-bit-word instruction set. Each cycle it takes the instruction word being executed, the word that follows it in program memory, the address of that following instruction, the zero and overflow status flags, the operand register byte and the working register. From these it works out the address of the next instruction to fetch. It also reports whether the already-fetched following instruction must be discarded, and how many extra cycles the instruction costs (0, 1 or 2).

It recognises four kinds of flow change. The first is the conditional relative branches on zero and overflow. The second is the unconditional relative branch. The third is the two-word absolute jump. The fourth is the skip families: unsigned compare against the working register, bit test, and increment/decrement with a zero test. Every other instruction, including a lone second word of a two-word instruction, falls through to the following address.

The result is registered. The outputs reflect the inputs sampled at the previous rising clock edge.

Top module: `flow_next_pc`

## Requirements
- R1: While rst_n is low, and after reset until the first sampled instruction, npc_o is 0, flush_o is 0 and xcyc_o is 0.
- R2: An instruction that is none of the flow encodings below gives npc_o equal to the sampled pc_next_i, with flush_o 0 and xcyc_o 0.
- R3: The conditional branches have instr[15:8] equal to 0xE0 (taken when Z=1), 0xE1 (taken when Z=0), 0xE4 (taken when OV=1) or 0xE5 (taken when OV=0). The offset n is the signed byte instr[7:0]. When taken, npc_o = pc_next_i + 2n, flush_o is 1 and xcyc_o is 1. When not taken, npc_o = pc_next_i, flush_o is 0 and xcyc_o is 0.
- R4: instr[15:11] = 11010 is an unconditional branch with a signed 11-bit offset n in instr[10:0]. It gives npc_o = pc_next_i + 2n, flush_o 1 and xcyc_o 1.
- R5: instr[15:8] = 0xEF is a two-word jump. It gives npc_o = {word2_i[11:0], instr[7:0], 0}, zero-extended to the PC width, with flush_o 1 and xcyc_o 1.
- R6: For bit tests, the bit index is instr[11:9] into reg_i. instr[15:12] = 1011 skips when that bit is 0, and 1010 skips when it is 1.
- R7: For unsigned compares of reg_i against wreg_i, instr[15:9] = 0110001 skips when they are equal, 0110010 skips when reg_i > wreg_i, and 0110000 skips when reg_i < wreg_i.
- R8: For counter skips, instr[15:10] = 001011 skips when reg_i-1 is 0, 001111 skips when reg_i+1 is 0 (8-bit wrap), 010011 skips when reg_i-1 is not 0, and 010010 skips when reg_i+1 is not 0.
- R9: A skip whose following word has word2_i[15:12] = 1111 gives npc_o = pc_next_i + 4 and xcyc_o 2. Any other skip gives npc_o = pc_next_i + 2 and xcyc_o 1. A skip always sets flush_o to 1, and a skip condition that is false behaves as in R2.
- R10: flush_o is 1 exactly when xcyc_o is nonzero, xcyc_o never reads 3, and a branch decision and a skip decision are never both active.
- R11: An instruction with instr[15:12] = 1111, executed on its own, is a no-op as in R2, whatever word2_i holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_i | input | 16 | Instruction word being executed |
| word2_i | input | 16 | Program word that follows the instruction |
| pc_next_i | input | 21 | Byte address of the following instruction |
| flag_z_i | input | 1 | Zero status flag |
| flag_ov_i | input | 1 | Overflow status flag |
| reg_i | input | 8 | Operand register byte |
| wreg_i | input | 8 | Working register |
| npc_o | output | 21 | Next fetch address |
| flush_o | output | 1 | Discard the prefetched instruction |
| xcyc_o | output | 2 | Extra cycles spent (0, 1 or 2) |

## Verification
A skip decision and the detection of a two-word following instruction fall in the same cycle. So does an orphan second word (top nibble 1111) being executed while the word after it also starts with 1111. The bench provokes both by forcing word2_i to a 1111 prefix on half of its random draws, on top of directed skips over two-word instructions. It judges the result by npc_o moving four bytes with xcyc_o of 2 for a true skip, and by a pure fall-through for the orphan word.

// File: rtl/flow_pkg.sv
package flow_pkg;
    typedef enum logic [3:0] {
        K_NONE, K_BRZ, K_BRNZ, K_BROV, K_BRNOV, K_BRA, K_JMP,
        K_TCLR, K_TSET, K_CEQ, K_CGT, K_CLT,
        K_DSZ, K_ISZ, K_DSNZ, K_ISNZ
    } kind_e;
endpackage

// File: rtl/flow_decode.sv
module flow_decode #(
    parameter int IW = 16
) (
    input  logic [IW-1:0]        instr,
    output flow_pkg::kind_e      kind,
    output logic [2:0]           bit_idx
);
    import flow_pkg::*;

    always_comb begin
        kind    = K_NONE;
        bit_idx = instr[11:9];
        casez (instr[15:8])
            8'hE0:        kind = K_BRZ;
            8'hE1:        kind = K_BRNZ;
            8'hE4:        kind = K_BROV;
            8'hE5:        kind = K_BRNOV;
            8'hEF:        kind = K_JMP;
            8'b11010???:  kind = K_BRA;
            8'b1011????:  kind = K_TCLR;
            8'b1010????:  kind = K_TSET;
            8'b0110001?:  kind = K_CEQ;
            8'b0110010?:  kind = K_CGT;
            8'b0110000?:  kind = K_CLT;
            8'b001011??:  kind = K_DSZ;
            8'b001111??:  kind = K_ISZ;
            8'b010011??:  kind = K_DSNZ;
            8'b010010??:  kind = K_ISNZ;
            default:      kind = K_NONE;
        endcase
    end
endmodule

// File: rtl/flow_cond.sv
module flow_cond #(
    parameter int DW = 8
) (
    input  flow_pkg::kind_e kind,
    input  logic [2:0]      bit_idx,
    input  logic            flag_z,
    input  logic            flag_ov,
    input  logic [DW-1:0]   reg_val,
    input  logic [DW-1:0]   wreg,
    output logic            take,
    output logic            skip
);
    import flow_pkg::*;

    localparam logic [DW-1:0] ONE  = DW'(1);
    localparam logic [DW-1:0] ONES = '1;

    logic sel_bit;
    assign sel_bit = reg_val[bit_idx];

    always_comb begin
        take = 1'b0;
        skip = 1'b0;
        unique case (kind)
            K_BRZ:   take = flag_z;
            K_BRNZ:  take = !flag_z;
            K_BROV:  take = flag_ov;
            K_BRNOV: take = !flag_ov;
            K_BRA,
            K_JMP:   take = 1'b1;
            K_TCLR:  skip = !sel_bit;
            K_TSET:  skip = sel_bit;
            K_CEQ:   skip = (reg_val == wreg);
            K_CGT:   skip = (reg_val > wreg);
            K_CLT:   skip = (reg_val < wreg);
            K_DSZ:   skip = (reg_val == ONE);
            K_ISZ:   skip = (reg_val == ONES);
            K_DSNZ:  skip = (reg_val != ONE);
            K_ISNZ:  skip = (reg_val != ONES);
            default: ;
        endcase
    end
endmodule

// File: rtl/flow_target.sv
module flow_target #(
    parameter int PCW = 21,
    parameter int IW  = 16
) (
    input  logic [IW-1:0]  instr,
    input  logic [IW-1:0]  word2,
    input  logic [PCW-1:0] pc_next,
    input  logic           long_ofs,
    output logic [PCW-1:0] rel_tgt,
    output logic [PCW-1:0] abs_tgt
);
    localparam int SHORT_W = 8;
    localparam int LONG_W  = 11;
    localparam int ABS_W   = 21;

    logic [PCW-1:0] disp;
    logic [PCW-1:0] disp_s;
    logic [PCW-1:0] disp_l;

    assign disp_s  = {{(PCW-SHORT_W){instr[SHORT_W-1]}}, instr[SHORT_W-1:0]};
    assign disp_l  = {{(PCW-LONG_W){instr[LONG_W-1]}}, instr[LONG_W-1:0]};
    assign disp    = long_ofs ? disp_l : disp_s;
    assign rel_tgt = pc_next + {disp[PCW-2:0], 1'b0};

    generate
        if (PCW > ABS_W) begin : g_wide
            assign abs_tgt = {{(PCW-ABS_W){1'b0}}, word2[11:0], instr[7:0], 1'b0};
        end else begin : g_exact
            logic [ABS_W-1:0] full;
            assign full    = {word2[11:0], instr[7:0], 1'b0};
            assign abs_tgt = full[PCW-1:0];
        end
    endgenerate
endmodule

// File: rtl/flow_next_pc.sv
module flow_next_pc #(
    parameter int PCW = 21,
    parameter int IW  = 16,
    parameter int DW  = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [IW-1:0]  instr_i,
    input  logic [IW-1:0]  word2_i,
    input  logic [PCW-1:0] pc_next_i,
    input  logic           flag_z_i,
    input  logic           flag_ov_i,
    input  logic [DW-1:0]  reg_i,
    input  logic [DW-1:0]  wreg_i,
    output logic [PCW-1:0] npc_o,
    output logic           flush_o,
    output logic [1:0]     xcyc_o
);
    import flow_pkg::*;

    localparam logic [3:0]     LONG_TAG = 4'hF;
    localparam logic [PCW-1:0] STEP1    = PCW'(2);
    localparam logic [PCW-1:0] STEP2    = PCW'(4);

    typedef struct packed {
        logic [PCW-1:0] npc;
        logic           flush;
        logic [1:0]     xcyc;
        logic           started;
    } st_t;

    st_t st_d, st_q;

    kind_e          kind;
    logic [2:0]     bit_idx;
    logic           take, skip;
    logic [PCW-1:0] rel_tgt, abs_tgt;
    logic           two_word;

    flow_decode #(.IW(IW)) u_dec (
        .instr(instr_i), .kind(kind), .bit_idx(bit_idx)
    );

    flow_cond #(.DW(DW)) u_cond (
        .kind(kind), .bit_idx(bit_idx), .flag_z(flag_z_i), .flag_ov(flag_ov_i),
        .reg_val(reg_i), .wreg(wreg_i), .take(take), .skip(skip)
    );

    flow_target #(.PCW(PCW), .IW(IW)) u_tgt (
        .instr(instr_i), .word2(word2_i), .pc_next(pc_next_i),
        .long_ofs(kind == K_BRA), .rel_tgt(rel_tgt), .abs_tgt(abs_tgt)
    );

    assign two_word = (word2_i[IW-1:IW-4] == LONG_TAG);

    always_comb begin
        st_d         = st_q;
        st_d.started = 1'b1;
        st_d.npc     = pc_next_i;
        st_d.flush   = 1'b0;
        st_d.xcyc    = 2'd0;
        if (take) begin
            st_d.npc   = (kind == K_JMP) ? abs_tgt : rel_tgt;
            st_d.flush = 1'b1;
            st_d.xcyc  = 2'd1;
        end else if (skip) begin
            st_d.npc   = pc_next_i + (two_word ? STEP2 : STEP1);
            st_d.flush = 1'b1;
            st_d.xcyc  = two_word ? 2'd2 : 2'd1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign npc_o   = st_q.npc;
    assign flush_o = st_q.flush;
    assign xcyc_o  = st_q.xcyc;

    assert_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (npc_o == '0 && !flush_o && xcyc_o == 2'd0));

    assert_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(take && skip));

    assert_xcyc_legal_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (xcyc_o != 2'd3) && (flush_o == (xcyc_o != 2'd0)));

    assert_orphan_nop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.started && $past(instr_i[IW-1:IW-4]) == LONG_TAG)
        |-> (!flush_o && npc_o == $past(pc_next_i)));

    assert_untaken_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.started && !flush_o) |-> (npc_o == $past(pc_next_i)));

    assert_skip_len_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.started && xcyc_o == 2'd2) |-> (npc_o == $past(pc_next_i) + STEP2));
endmodule

// File: tb/flow_next_pc_test.sv
`timescale 1ns/1ps
module flow_next_pc_test;
    localparam int PCW = 21;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [15:0] instr_i = '0, word2_i = '0;
    logic [PCW-1:0] pc_next_i = '0;
    logic flag_z_i = 1'b0, flag_ov_i = 1'b0;
    logic [7:0] reg_i = '0, wreg_i = '0;
    logic [PCW-1:0] npc_o;
    logic flush_o;
    logic [1:0] xcyc_o;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    flow_next_pc uut (
        .clk(clk), .rst_n(rst_n), .instr_i(instr_i), .word2_i(word2_i),
        .pc_next_i(pc_next_i), .flag_z_i(flag_z_i), .flag_ov_i(flag_ov_i),
        .reg_i(reg_i), .wreg_i(wreg_i), .npc_o(npc_o), .flush_o(flush_o),
        .xcyc_o(xcyc_o)
    );

    function automatic string tag_of(input logic [15:0] i);
        casez (i)
            16'b1110_0000_????????, 16'b1110_0001_????????,
            16'b1110_0100_????????, 16'b1110_0101_????????: return "R3";
            16'b11010???????????: return "R4";
            16'b1110_1111_????????: return "R5";
            16'b101?????????????: return "R6";
            16'b0110_000?????????, 16'b0110_001?????????,
            16'b0110_010?????????: return "R7";
            16'b0010_11??????????, 16'b0011_11??????????,
            16'b0100_11??????????, 16'b0100_10??????????: return "R8";
            16'b1111????????????: return "R11";
            default: return "R2";
        endcase
    endfunction

    // returns {npc, flush, xcyc}
    function automatic logic [PCW+2:0] model(
        input logic [15:0] i, input logic [15:0] w2, input logic [PCW-1:0] pcn,
        input logic z, input logic ov, input logic [7:0] r, input logic [7:0] w);
        int d;
        logic tk, sk;
        logic [7:0] dec, inc;
        tk = 1'b0; sk = 1'b0; d = 0;
        dec = r - 8'd1; inc = r + 8'd1;
        casez (i)
            16'b1110_0000_????????: begin tk = z;   d = $signed(i[7:0]); end
            16'b1110_0001_????????: begin tk = !z;  d = $signed(i[7:0]); end
            16'b1110_0100_????????: begin tk = ov;  d = $signed(i[7:0]); end
            16'b1110_0101_????????: begin tk = !ov; d = $signed(i[7:0]); end
            16'b11010???????????:   begin tk = 1'b1; d = $signed(i[10:0]); end
            16'b1110_1111_????????:
                return {PCW'({w2[11:0], i[7:0], 1'b0}), 1'b1, 2'd1};
            16'b1011????????????: sk = (r[i[11:9]] == 1'b0);
            16'b1010????????????: sk = (r[i[11:9]] == 1'b1);
            16'b0110_001?????????: sk = (r == w);
            16'b0110_010?????????: sk = (r > w);
            16'b0110_000?????????: sk = (r < w);
            16'b0010_11??????????: sk = (dec == 8'd0);
            16'b0011_11??????????: sk = (inc == 8'd0);
            16'b0100_11??????????: sk = (dec != 8'd0);
            16'b0100_10??????????: sk = (inc != 8'd0);
            default: ;
        endcase
        if (tk) return {pcn + PCW'(2 * d), 1'b1, 2'd1};
        if (sk) begin
            if (w2[15:12] == 4'hF) return {pcn + PCW'(4), 1'b1, 2'd2};
            return {pcn + PCW'(2), 1'b1, 2'd1};
        end
        return {pcn, 1'b0, 2'd0};
    endfunction

    task automatic check(input string tag, input logic [PCW+2:0] exp);
        total++;
        if ({npc_o, flush_o, xcyc_o} !== exp) begin
            bad++;
            $display("FAIL %s instr=%h: got npc=%h flush=%b xcyc=%0d, exp npc=%h flush=%b xcyc=%0d",
                     tag, instr_i, npc_o, flush_o, xcyc_o,
                     exp[PCW+2:3], exp[2], exp[1:0]);
        end
    endtask

    task automatic run(input logic [15:0] i, input logic [15:0] w2,
                       input logic [PCW-1:0] pcn, input logic z, input logic ov,
                       input logic [7:0] r, input logic [7:0] w, input string tag);
        logic [PCW+2:0] exp;
        instr_i = i; word2_i = w2; pc_next_i = pcn;
        flag_z_i = z; flag_ov_i = ov; reg_i = r; wreg_i = w;
        exp = model(i, w2, pcn, z, ov, r, w);
        @(negedge clk);
        check(tag, exp);
    endtask

    function automatic logic [15:0] pick_instr();
        logic [15:0] i;
        i = 16'($urandom);
        case ($urandom % 9)
            0: i[15:8] = 8'hE0 | 8'($urandom % 2) | 8'(($urandom % 2) << 2);
            1: i[15:11] = 5'b11010;
            2: i[15:8] = 8'hEF;
            3: i[15:13] = 3'b101;
            4: i[15:9] = 7'b0110000 | 7'($urandom % 3);
            5: case ($urandom % 4)
                   0: i[15:10] = 6'b001011;
                   1: i[15:10] = 6'b001111;
                   2: i[15:10] = 6'b010011;
                   default: i[15:10] = 6'b010010;
               endcase
            6: i[15:12] = 4'hF;
            default: ;
        endcase
        return i;
    endfunction

    function automatic logic [7:0] pick_byte();
        case ($urandom % 4)
            0: return 8'h00;
            1: return 8'h01;
            2: return 8'hFF;
            default: return 8'($urandom);
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: run did not finish, exp completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R1: outputs cleared while reset is held
        check("R1", '0);
        @(negedge clk);
        rst_n = 1'b1;
        check("R1", '0);

        // R2 non-flow, R11 orphan second word (next word also 1111)
        run(16'h0E55, 16'hF000, 21'h001000, 1, 1, 8'h00, 8'h00, "R2");
        run(16'hF123, 16'hF456, 21'h000200, 1, 1, 8'h01, 8'h01, "R11");
        // R3 conditional branches, boundary offsets
        run(16'hE080, 16'h0000, 21'h000400, 1, 0, 8'h00, 8'h00, "R3");
        run(16'hE07F, 16'h0000, 21'h000400, 0, 0, 8'h00, 8'h00, "R3");
        run(16'hE17F, 16'h0000, 21'h000400, 0, 0, 8'h00, 8'h00, "R3");
        run(16'hE410, 16'h0000, 21'h000010, 0, 1, 8'h00, 8'h00, "R3");
        run(16'hE5F0, 16'h0000, 21'h000010, 0, 1, 8'h00, 8'h00, "R3");
        run(16'hE5F0, 16'h0000, 21'h000004, 0, 0, 8'h00, 8'h00, "R3");
        // R4 unconditional branch, both offset extremes and wrap
        run(16'hD400, 16'h0000, 21'h000800, 0, 0, 8'h00, 8'h00, "R4");
        run(16'hD3FF, 16'h0000, 21'h1FFFFE, 0, 0, 8'h00, 8'h00, "R4");
        // R5 two-word jump
        run(16'hEFAB, 16'hFCDE, 21'h000100, 0, 0, 8'h00, 8'h00, "R5");
        // R6 bit tests
        run(16'hBE00, 16'h0000, 21'h000100, 0, 0, 8'h7F, 8'h00, "R6");
        run(16'hAE00, 16'hF000, 21'h000100, 0, 0, 8'h80, 8'h00, "R6");
        run(16'hA200, 16'h0000, 21'h000100, 0, 0, 8'hFE, 8'h00, "R6");
        // R7 unsigned compares
        run(16'h6200, 16'h0000, 21'h000100, 0, 0, 8'h5A, 8'h5A, "R7");
        run(16'h6400, 16'h0000, 21'h000100, 0, 0, 8'hFF, 8'h00, "R7");
        run(16'h6000, 16'h0000, 21'h000100, 0, 0, 8'h80, 8'h7F, "R7");
        run(16'h6000, 16'h0000, 21'h000100, 0, 0, 8'h7F, 8'h80, "R7");
        // R8 counter skips
        run(16'h2C00, 16'h0000, 21'h000100, 0, 0, 8'h01, 8'h00, "R8");
        run(16'h3C00, 16'hF000, 21'h000100, 0, 0, 8'hFF, 8'h00, "R8");
        run(16'h4C00, 16'h0000, 21'h000100, 0, 0, 8'h01, 8'h00, "R8");
        run(16'h4800, 16'h0000, 21'h000100, 0, 0, 8'h00, 8'h00, "R8");
        // R9 skip over two-word instruction vs one-word
        run(16'h6200, 16'hF000, 21'h000100, 0, 0, 8'h11, 8'h11, "R9");
        run(16'h6200, 16'hE000, 21'h000100, 0, 0, 8'h11, 8'h11, "R9");

        for (int k = 0; k < 3000; k++) begin
            logic [15:0] i, w2;
            logic [PCW-1:0] pcn;
            logic [7:0] r;
            i   = pick_instr();
            w2  = 16'($urandom);
            if ($urandom % 2 == 1) w2[15:12] = 4'hF;
            pcn = PCW'($urandom) & ~PCW'(1);
            r   = pick_byte();
            run(i, w2, pcn, 1'($urandom), 1'($urandom), r,
                ($urandom % 3 == 0) ? r : pick_byte(), tag_of(i));
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule